// File: doc/BRIEF.md
# Output Compare Channel

A single compare channel that watches an external free-running counter and reports when the counter reaches a programmed value. The compare value is a 16-bit quantity built from two byte-wide registers. On a match the block sets a sticky match flag. That flag can raise an interrupt request and can load a programmed level onto an output pin.

Software reaches the channel over a byte-wide register bus with an address, a read strobe, a write strobe and write data. Read data is combinational and is driven only while the read strobe is high. The match flag is cleared only by a deliberate two-step handshake: first a status read while the flag is set, then any access to the compare low byte. A force bit can lock the pin onto the programmed level. Software can set this bit but only reset can clear it. When compare is not in use, the two compare registers serve as plain storage.

Register addresses: 0 status (bit 0 match flag, other bits read 0, writes ignored); 1 control A (bit 0 interrupt enable, bit 1 output level); 2 control B (bit 0 pin enable, bit 1 force level); 3 compare high byte; 4 compare low byte. Other addresses read 0.

Top module: `ocmp_channel`

## Requirements
- R1: After reset, the match flag, interrupt, pin output, pin enable and every register read 0.
- R2: The compare high byte (address 3) and low byte (address 4) read back the last value written, whether or not a match is in use.
- R3: When the counter input equals {high, low}, status bit 0 reads 1 from the next cycle on and stays 1 until it is cleared as in R4.
- R4: A status read (address 0) while the flag is set arms the clear. A later read or write of address 4 clears the flag in the following cycle and consumes the arming.
- R5: A status read while the flag is clear does not arm the clear. An access to address 4 with no arming pending leaves the flag unchanged.
- R6: A match in the same cycle as the completing address-4 access wins, so the flag stays set.
- R7: irq is high exactly while the flag is set and control A bit 0 is 1.
- R8: pin_oe equals control B bit 0. While it is 0, pin_out is 0.
- R9: Each time the flag goes from 0 to 1, control A bit 1 is copied into the pin latch. pin_out shows that latch while the pin is enabled and force is off.
- R10: Writing 1 to control B bit 1 sets force. Writing 0 does not clear it, and only reset does. While force is set and the pin is enabled, pin_out follows control A bit 1 in the same cycle.
- R11: Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when bus_rd is low |
| cnt_value | input | 16 | Free-running counter value |
| pin_out | output | 1 | Compare pin level |
| pin_oe | output | 1 | Compare pin driven by the timer |
| irq | output | 1 | Compare interrupt request |

## Verification
Some properties are checked on every cycle. A match always sets the flag and a set flag stays set. The flag never drops without a pending armed clear. The force bit is sticky. The pin latch moves only on a flag set event. A disabled pin stays low, and a forced, enabled pin tracks the level bit. Only the bench's scenarios can show the rest: the exact order of the clear handshake, the result of an unarmed status read, the tie between a match and a clear, and the register read-back values. The bench replays these against its own register model under random bus traffic and in directed sequences.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int unsigned OFS_STAT = 0;
  localparam int unsigned OFS_CTLA = 1;
  localparam int unsigned OFS_CTLB = 2;
  localparam int unsigned OFS_CMPH = 3;
  localparam int unsigned OFS_CMPL = 4;

  typedef struct packed {
    logic ien;   // interrupt enable
    logic lvl;   // programmed output level
    logic oen;   // pin enable
    logic frc;   // sticky force-level
  } ctl_t;

  function automatic logic pin_drive(input ctl_t c, input logic latch);
    if (!c.oen) return 1'b0;
    return c.frc ? c.lvl : latch;
  endfunction

  function automatic logic flag_next(input logic cur, input logic hit,
                                     input logic clr);
    if (hit) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs
  import ocmp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     rd,
  input  logic                     wr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     flag,
  output logic [DATA_W-1:0]        rdata,
  output logic [NBYTES*DATA_W-1:0] cmp,
  output ctl_t                     ctl,
  output logic                     stat_rd,
  output logic                     lo_access
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CTLA = ADDR_W'(OFS_CTLA);
  localparam logic [ADDR_W-1:0] A_CTLB = ADDR_W'(OFS_CTLB);
  localparam logic [ADDR_W-1:0] A_CMPL = ADDR_W'(OFS_CMPL);

  logic [DATA_W-1:0] bytes_q [NBYTES];

  // Compare bytes: byte b sits at address OFS_CMPL - b.
  genvar b;
  generate
    for (b = 0; b < NBYTES; b++) begin : g_cmp
      localparam logic [ADDR_W-1:0] A_B = ADDR_W'(OFS_CMPL - b);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              bytes_q[b] <= '0;
        else if (wr && addr == A_B) bytes_q[b] <= wdata;
      end
      assign cmp[b*DATA_W +: DATA_W] = bytes_q[b];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr) begin
      if (addr == A_CTLA) begin
        ctl.ien <= wdata[0];
        ctl.lvl <= wdata[1];
      end
      if (addr == A_CTLB) begin
        ctl.oen <= wdata[0];
        ctl.frc <= ctl.frc | wdata[1];
      end
    end
  end

  assign stat_rd   = rd && (addr == A_STAT);
  assign lo_access = (rd || wr) && (addr == A_CMPL);

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (addr == A_STAT) rdata[0] = flag;
      else if (addr == A_CTLA) rdata[1:0] = {ctl.lvl, ctl.ien};
      else if (addr == A_CTLB) rdata[1:0] = {ctl.frc, ctl.oen};
      else begin
        for (int i = 0; i < NBYTES; i++)
          if (addr == ADDR_W'(OFS_CMPL - i)) rdata = bytes_q[i];
      end
    end
  end
endmodule

// File: rtl/ocmp_flag.sv
module ocmp_flag
  import ocmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             stat_rd,
  input  logic             lo_access,
  output logic             flag_q,
  output logic             arm_q,
  output logic             match_hit,
  output logic             set_evt,
  output logic             clr_evt
);
  assign match_hit = (cnt == cmp);
  assign set_evt   = match_hit && !flag_q;
  assign clr_evt   = arm_q && lo_access;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_next(flag_q, match_hit, clr_evt);
      if (clr_evt)                arm_q <= 1'b0;
      else if (stat_rd && flag_q) arm_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ocmp_pin.sv
module ocmp_pin
  import ocmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  ctl_t ctl,
  output logic pin_latch,
  output logic pin_out,
  output logic pin_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pin_latch <= 1'b0;
    else if (set_evt) pin_latch <= ctl.lvl;
  end

  assign pin_out = pin_drive(ctl, pin_latch);
  assign pin_oe  = ctl.oen;
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
  import ocmp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_rd,
  input  logic                     bus_wr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic [NBYTES*DATA_W-1:0] cnt_value,
  output logic                     pin_out,
  output logic                     pin_oe,
  output logic                     irq
);
  localparam int CNT_W = NBYTES * DATA_W;

  logic [CNT_W-1:0] cmp;
  ctl_t             ctl;
  logic             stat_rd, lo_access;
  logic             flag_q, arm_q, match_hit, set_evt, clr_evt;
  logic             pin_latch;

  ocmp_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NBYTES(NBYTES)) regs_i (
    .clk, .rst_n, .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
    .wdata(bus_wdata), .flag(flag_q), .rdata(bus_rdata), .cmp, .ctl,
    .stat_rd, .lo_access
  );

  ocmp_flag #(.CNT_W(CNT_W)) flag_i (
    .clk, .rst_n, .cnt(cnt_value), .cmp, .stat_rd, .lo_access,
    .flag_q, .arm_q, .match_hit, .set_evt, .clr_evt
  );

  ocmp_pin pin_i (
    .clk, .rst_n, .set_evt, .ctl, .pin_latch, .pin_out, .pin_oe
  );

  assign irq = flag_q && ctl.ien;
endmodule

// File: rtl/ocmp_channel_chk.sv
module ocmp_channel_chk
  import ocmp_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic match_hit,
  input logic set_evt,
  input logic clr_evt,
  input logic arm_q,
  input logic flag_q,
  input ctl_t ctl,
  input logic pin_latch,
  input logic pin_out,
  input logic pin_oe,
  input logic irq
);
  AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |=> flag_q); // R3
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_evt) |=> flag_q); // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && clr_evt && !match_hit) |=> !flag_q); // R4
  AST_NO_CLEAR_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !arm_q) |=> flag_q); // R5
  AST_TIE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && match_hit) |=> flag_q); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag_q && ctl.ien)); // R7
  AST_PIN_LOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out); // R8
  AST_LATCH_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !set_evt |=> $stable(pin_latch)); // R9
  AST_FORCE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.frc |=> ctl.frc); // R10
  AST_FORCE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.frc && pin_oe) |-> (pin_out == ctl.lvl)); // R10
endmodule

bind ocmp_channel ocmp_channel_chk chk_i (.*);

// File: tb/ocmp_channel_tb_top.sv
`timescale 1ns/1ps
module ocmp_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [15:0] cnt_value = 16'hFFFF;
  logic        pin_out, pin_oe, irq;

  int n_chk = 0, n_bad = 0;

  // bench model of the register state
  logic [7:0] m_hi, m_lo;
  logic m_ien, m_lvl, m_oen, m_frc, m_flag, m_arm, m_pin;

  always #2 clk = ~clk;

  ocmp_channel dut_i (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {7'd0, m_flag};
      3'd1: return {6'd0, m_lvl, m_ien};
      3'd2: return {6'd0, m_frc, m_oen};
      3'd3: return m_hi;
      3'd4: return m_lo;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic exp_pin();
    if (m_oen == 1'b0) return 1'b0;
    if (m_frc) return m_lvl;
    return m_pin;
  endfunction

  task automatic model_reset();
    {m_hi, m_lo} = '0;
    {m_ien, m_lvl, m_oen, m_frc, m_flag, m_arm, m_pin} = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_rd = 0; bus_wr = 0; cnt_value = 16'hFFFF;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic outs(input string tag);
    chk({tag, " R7 irq"}, 16'(irq), 16'(m_flag & m_ien));
    chk({tag, " R8 oe"}, 16'(pin_oe), 16'(m_oen));
    chk({tag, " R9 pin"}, 16'(pin_out), 16'(exp_pin()));
  endtask

  // one bus cycle, starting and ending at a falling edge
  task automatic step(input logic [2:0] a, input logic rd, input logic wr,
                      input logic [7:0] d, input logic [15:0] c, input string tag);
    logic hit, lo, clr;
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = d; cnt_value = c;
    #1;
    if (rd) chk({tag, " R2 read"}, 16'(bus_rdata), 16'(exp_read(a)));
    hit = (c == {m_hi, m_lo});
    lo  = (rd || wr) && a == 3'd4;
    clr = m_arm && lo;
    @(posedge clk);
    if (hit && !m_flag) m_pin = m_lvl;
    if (clr) m_arm = 1'b0;
    else if (rd && a == 3'd0 && m_flag) m_arm = 1'b1;
    m_flag = hit ? 1'b1 : (clr ? 1'b0 : m_flag);
    if (wr) begin
      if (a == 3'd1) begin m_ien = d[0]; m_lvl = d[1]; end
      if (a == 3'd2) begin m_oen = d[0]; m_frc = m_frc | d[1]; end
      if (a == 3'd3) m_hi = d;
      if (a == 3'd4) m_lo = d;
    end
    @(negedge clk);
    bus_rd = 0; bus_wr = 0;
    outs(tag);
  endtask

  task automatic rd_stat_expect(input logic f, input string req);
    bus_addr = 3'd0; bus_rd = 1'b1; bus_wr = 1'b0;
    #1; chk({req, " flag"}, 16'(bus_rdata[0]), 16'(f));
    step(3'd0, 1, 0, 8'h00, cnt_value, req);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_0c01));
    do_reset();
    // R1 reset state
    chk("R1 irq", 16'(irq), 0);
    chk("R1 pin", 16'(pin_out), 0);
    chk("R1 oe", 16'(pin_oe), 0);
    for (int a = 0; a < 6; a++) step(3'(a), 1, 0, 8'h00, 16'hFFFF, "R1");

    // random traffic; force bit kept off here
    for (int i = 0; i < 600; i++) begin
      logic [2:0] a; logic [7:0] d; logic [15:0] c; logic r, w;
      a = 3'($urandom_range(0, 5));
      r = 1'($urandom); w = !r && ($urandom_range(0, 2) != 0);
      d = 8'($urandom);
      if (a == 3'd2) d[1] = 1'b0;
      c = ($urandom_range(0, 1) == 0) ? {m_hi, m_lo} : 16'($urandom);
      step(a, r, w, d, c, "RND");
    end

    do_reset();
    // R2 storage
    step(3'd3, 0, 1, 8'h12, 16'hFFFF, "R2");
    step(3'd4, 0, 1, 8'h34, 16'hFFFF, "R2");
    step(3'd3, 1, 0, 8'h00, 16'hFFFF, "R2");
    step(3'd4, 1, 0, 8'h00, 16'hFFFF, "R2");
    step(3'd1, 0, 1, 8'h03, 16'hFFFF, "R7");
    step(3'd2, 0, 1, 8'h01, 16'hFFFF, "R8");
    // R3 match sets flag, pin gets level 1 (R9)
    step(3'd0, 0, 0, 8'h00, 16'h1234, "R3");
    chk("R3 flag irq", 16'(irq), 1);
    chk("R9 pin set", 16'(pin_out), 1);
    step(3'd0, 0, 0, 8'h00, 16'h0000, "R3");
    chk("R3 sticky", 16'(irq), 1);
    // R5 lo access with no arming
    step(3'd4, 1, 0, 8'h00, 16'h0000, "R5");
    rd_stat_expect(1'b1, "R5");
    // R4: armed by status read above, now access lo
    step(3'd4, 1, 0, 8'h00, 16'h0000, "R4");
    chk("R4 cleared", 16'(irq), 0);
    // R9 latch held after clear; change level, pin keeps 1
    step(3'd1, 0, 1, 8'h01, 16'h0000, "R9");
    chk("R9 hold", 16'(pin_out), 1);
    // R5 status read with flag clear does not arm
    rd_stat_expect(1'b0, "R5");
    step(3'd0, 0, 0, 8'h00, 16'h1234, "R5");
    step(3'd4, 0, 1, 8'h34, 16'h0000, "R5");
    chk("R5 unarmed keep", 16'(irq), 1);
    chk("R9 new level", 16'(pin_out), 0);
    // R6 tie: arm, then lo access together with a match
    rd_stat_expect(1'b1, "R6");
    step(3'd4, 1, 0, 8'h00, 16'h1234, "R6");
    chk("R6 tie keeps", 16'(irq), 1);
    // R11 status write ignored
    step(3'd0, 0, 1, 8'h00, 16'h0000, "R11");
    rd_stat_expect(1'b1, "R11");
    // R10 force
    step(3'd2, 0, 1, 8'h03, 16'h0000, "R10");
    step(3'd1, 0, 1, 8'h03, 16'h0000, "R10");
    chk("R10 follow hi", 16'(pin_out), 1);
    step(3'd1, 0, 1, 8'h01, 16'h0000, "R10");
    chk("R10 follow lo", 16'(pin_out), 0);
    step(3'd2, 0, 1, 8'h01, 16'h0000, "R10");
    step(3'd2, 1, 0, 8'h00, 16'h0000, "R10");
    chk("R10 sticky", 16'(m_frc), 1);
    // R8 disable with force still set
    step(3'd1, 0, 1, 8'h03, 16'h0000, "R8");
    step(3'd2, 0, 1, 8'h00, 16'h0000, "R8");
    chk("R8 off low", 16'(pin_out), 0);
    chk("R8 oe low", 16'(pin_oe), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule